// File: doc/BRIEF.md
# Bit-Serial Radix-2 Butterfly

This block computes one radix-2 FFT butterfly on complex operands that arrive one bit per clock, least significant bit first. Six 1-bit serial lines carry the operand A, the operand B and the twiddle factor W, each as a real and an imaginary part. A `start` pulse frames the first bit. The block forms the complex product W·B with four shift-and-add signed multipliers. It then streams the sum X = A + W·B and the difference Y = A − W·B out on four 1-bit lines. A one-cycle `finish` pulse marks the last output bit.

All of the arithmetic passes through ten 1-bit adder/subtractor cells, each with a registered carry. Four sit in the multipliers and six in the output combine. The multipliers walk the twiddle bits one row at a time. Every row in which both twiddle parts hold a zero bit is skipped in a single cycle, so the run time depends on the data. The host that feeds coefficients and data can read the run length from the positions of the nonzero twiddle bits.

Top module: `bsb_butterfly`

## Requirements
- R1: While idle, a cycle with `start` high captures bit 0 of all six operand lines. Bits 1 to WIDTH−1 are captured on the following WIDTH−1 cycles, LSB first, in two's complement.
- R2: The outputs carry X = A + W·B and Y = A − W·B exactly, as OW = 2·WIDTH+1 bit two's complement values sent LSB first. Re(W·B) = Wr·Br − Wi·Bi and Im(W·B) = Wr·Bi + Wi·Br.
- R3: The OW result bits appear on OW consecutive cycles. The last of these cycles is the one in which `finish` is high, and `finish` is high for exactly one cycle per butterfly.
- R4: Count the clock edges after the edge that samples `start`. `finish` rises on edge number WIDTH−1 + M + OW. M adds 2·WIDTH for each bit row j in which Wr[j] or Wi[j] is 1, and 1 for each row in which both are 0.
- R5: A twiddle factor of zero in both parts costs WIDTH multiply cycles in total and yields X = Y = A.
- R6: `start` is ignored while a butterfly is in progress. The result bits and the `finish` timing are unchanged by it.
- R7: After reset, `finish` and all four outputs are 0 and the block is idle.
- R8: Operands equal to −2^(WIDTH−1) in every part give exact results. This covers the sign row of the multiplier.
- R9: A new `start` is accepted on the cycle right after `finish`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Frames bit 0 of the operands while idle |
| a_re | input | 1 | Serial real part of A |
| a_im | input | 1 | Serial imaginary part of A |
| b_re | input | 1 | Serial real part of B |
| b_im | input | 1 | Serial imaginary part of B |
| w_re | input | 1 | Serial real part of the twiddle factor |
| w_im | input | 1 | Serial imaginary part of the twiddle factor |
| x_re | output | 1 | Serial real part of A + W·B |
| x_im | output | 1 | Serial imaginary part of A + W·B |
| y_re | output | 1 | Serial real part of A − W·B |
| y_im | output | 1 | Serial imaginary part of A − W·B |
| finish | output | 1 | One-cycle pulse with the last result bit |

## Verification
The assertions assume that `start` is meaningful only while the block is idle. They also assume that each operand word is presented as exactly WIDTH consecutive bits starting in the `start` cycle, and that WIDTH is at least 2. The stimulus drives every word over precisely that window and holds the lines at zero otherwise. The one exception is a deliberate mid-run `start` carrying garbage bits, used to show that the block ignores it. The twiddle values are chosen to mix fully skipped rows, fully active rows and sparse patterns, so that every path through the row controller is visited.

// File: rtl/bsb_pkg.sv
// Shared types for the bit-serial butterfly.
package bsb_pkg;
    // Controller phases: idle, operand load, row-wise multiply, result stream.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_MUL  = 2'd2,
        ST_OUT  = 2'd3
    } bsb_state_e;
endpackage

// File: rtl/bsb_cell.sv
// One-bit adder/subtractor with a registered carry.
// Assumes the operand bits arrive LSB first. 'first' marks bit 0, where
// the carry-in is forced to 'sub'. This makes the cell compute a + b when
// sub=0 and a - b (as a + ~b + 1) when sub=1. The carry only updates
// when 'en' is high.
module bsb_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic first,
    input  logic sub,
    input  logic in_a,
    input  logic in_b,
    output logic s
);
    logic cy_q;
    logic b_eff;
    logic cin;

    // Sum bit with optional inversion of the second operand.
    always_comb begin
        b_eff = in_b ^ sub;
        cin   = first ? sub : cy_q;
        s     = in_a ^ b_eff ^ cin;
    end

    // Carry (or inverted borrow) register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cy_q <= 1'b0;
        else if (en)
            cy_q <= (in_a & b_eff) | (in_a & cin) | (b_eff & cin);
    end
endmodule

// File: rtl/bsb_ctrl.sv
// Shared controller for the butterfly.
// It captures the twiddle words and walks the WIDTH multiplier rows. A row
// takes 2*WIDTH column cycles, or a single cycle when both twiddle bits of
// that row are 0. It then counts the OW result cycles and pulses finish
// with the last one. Assumes WIDTH >= 2.
module bsb_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      w_re,
    input  logic                      w_im,
    output bsb_pkg::bsb_state_e       st,
    output logic [$clog2(WIDTH)-1:0]  row,
    output logic [$clog2(2*WIDTH+2)-1:0] cnt,
    output logic                      load_en,
    output logic                      acc_en,
    output logic                      mbit_r,
    output logic                      mbit_i,
    output logic                      last_row,
    output logic                      finish
);
    import bsb_pkg::*;

    localparam int RW   = $clog2(WIDTH);
    localparam int OW   = 2 * WIDTH + 1;
    localparam int CW   = $clog2(2 * WIDTH + 2);
    localparam logic [RW-1:0] ROW_LAST  = RW'(WIDTH - 1);
    localparam logic [CW-1:0] LOAD_LAST = CW'(WIDTH - 1);
    localparam logic [CW-1:0] COL_LAST  = CW'(2 * WIDTH - 1);
    localparam logic [CW-1:0] OUT_LAST  = CW'(OW - 1);

    bsb_state_e         st_q;
    logic [RW-1:0]      row_q;
    logic [CW-1:0]      cnt_q;
    logic [WIDTH-1:0]   wr_q;
    logic [WIDTH-1:0]   wi_q;
    logic               finish_q;
    logic               skip;

    // Row decode: current multiplicand bits and whether the row may be skipped.
    always_comb begin
        mbit_r   = wr_q[row_q];
        mbit_i   = wi_q[row_q];
        skip     = !(mbit_r | mbit_i);
        last_row = (row_q == ROW_LAST);
        load_en  = ((st_q == ST_IDLE) && start) || (st_q == ST_LOAD);
        acc_en   = (st_q == ST_MUL) && !((cnt_q == '0) && skip);
    end

    // Twiddle word shift registers, filled LSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            wi_q <= '0;
        end else if (load_en) begin
            wr_q <= {w_re, wr_q[WIDTH-1:1]};
            wi_q <= {w_im, wi_q[WIDTH-1:1]};
        end
    end

    // Phase, row and column sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            row_q <= '0;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q  <= ST_LOAD;
                        row_q <= '0;
                        cnt_q <= CW'(1);
                    end
                end
                ST_LOAD: begin
                    if (cnt_q == LOAD_LAST) begin
                        st_q  <= ST_MUL;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_MUL: begin
                    if (((cnt_q == '0) && skip) || (cnt_q == COL_LAST)) begin
                        cnt_q <= '0;
                        if (last_row)
                            st_q <= ST_OUT;
                        else
                            row_q <= row_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == OUT_LAST) begin
                        st_q  <= ST_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Finish pulse, registered together with the last result bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            finish_q <= 1'b0;
        else
            finish_q <= (st_q == ST_OUT) && (cnt_q == OUT_LAST);
    end

    assign st     = st_q;
    assign row    = row_q;
    assign cnt    = cnt_q;
    assign finish = finish_q;

    // R3
    finish_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish_q |=> !finish_q);

    // R3
    finish_after_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(finish_q) |-> ($past(st_q) == ST_OUT));

    // R5
    row_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_MUL) && (cnt_q == '0) && skip && !last_row)
        |=> ((row_q == $past(row_q) + 1'b1) && (cnt_q == '0)));

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (st_q == ST_MUL)) |=> (st_q != ST_LOAD));
endmodule

// File: rtl/bsb_mult.sv
// Serial signed shift-and-add multiplier: P = Q * M at 2*WIDTH bits.
// The product register circulates through one adder/subtractor cell, one
// bit per column cycle. In row j the addend bit is the sign-extended Q
// shifted by j, gated by the multiplicand bit. The sign row subtracts.
// The controller skips rows whose shared multiplicand bits are zero.
// During the result phase the product shifts out LSB first with
// sign extension.
module bsb_mult #(
    parameter int WIDTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          acc_en,
    input  logic                          shift_en,
    input  logic                          last_row,
    input  logic                          mbit,
    input  logic [$clog2(WIDTH)-1:0]      row,
    input  logic [$clog2(2*WIDTH+2)-1:0]  col,
    input  logic [WIDTH-1:0]              q,
    output logic                          pbit
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0] p_q;
    logic          qbit;
    logic          sum;

    // Addend bit: Q sign-extended and shifted left by the row index.
    always_comb begin
        int d;
        d = int'(col) - int'(row);
        if (d < 0)
            qbit = 1'b0;
        else if (d >= WIDTH - 1)
            qbit = q[WIDTH-1];
        else
            qbit = q[d];
    end

    bsb_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (acc_en),
        .first (col == '0),
        .sub   (last_row),
        .in_a  (p_q[0]),
        .in_b  (mbit & qbit),
        .s     (sum)
    );

    // Product register: clear at start, rotate through the cell, then stream out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            p_q <= '0;
        else if (clr)
            p_q <= '0;
        else if (acc_en)
            p_q <= {sum, p_q[PW-1:1]};
        else if (shift_en)
            p_q <= {p_q[PW-1], p_q[PW-1:1]};
    end

    assign pbit = p_q[0];

    // R5
    prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !acc_en && !shift_en) |=> $stable(p_q));
endmodule

// File: rtl/bsb_butterfly.sv
// Bit-serial radix-2 butterfly: X = A + W*B, Y = A - W*B.
// Operands are WIDTH-bit two's complement words, LSB first, with bit 0 in
// the start cycle. Results are OW = 2*WIDTH+1 bits, LSB first, on
// registered outputs. The last bit coincides with the finish pulse.
// Four multipliers form Wr*Br, Wi*Bi, Wr*Bi and Wi*Br. Six cells then
// form the real and imaginary products and their sum and difference
// with A.
module bsb_butterfly #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic a_re,
    input  logic a_im,
    input  logic b_re,
    input  logic b_im,
    input  logic w_re,
    input  logic w_im,
    output logic x_re,
    output logic x_im,
    output logic y_re,
    output logic y_im,
    output logic finish
);
    import bsb_pkg::*;

    localparam int RW = $clog2(WIDTH);
    localparam int CW = $clog2(2 * WIDTH + 2);
    localparam int NOPS = 4;   // A real, A imag, B real, B imag
    localparam int NMUL = 4;

    bsb_state_e       st;
    logic [RW-1:0]    row;
    logic [CW-1:0]    cnt;
    logic             load_en, acc_en, mbit_r, mbit_i, last_row;
    logic             out_en, clr;
    logic [NOPS-1:0]  ser_in;
    logic [WIDTH-1:0] opr_q [NOPS];
    logic [NMUL-1:0]  pbit;
    logic             a_bit_r, a_bit_i;
    logic             t_re, t_im, sx_re, sx_im, sy_re, sy_im;
    logic             x_re_q, x_im_q, y_re_q, y_im_q;

    bsb_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .w_re     (w_re),
        .w_im     (w_im),
        .st       (st),
        .row      (row),
        .cnt      (cnt),
        .load_en  (load_en),
        .acc_en   (acc_en),
        .mbit_r   (mbit_r),
        .mbit_i   (mbit_i),
        .last_row (last_row),
        .finish   (finish)
    );

    assign clr    = (st == ST_IDLE) && start;
    assign out_en = (st == ST_OUT);
    assign ser_in = {b_im, b_re, a_im, a_re};

    // Operand shift registers, one per serial data line.
    for (genvar g = 0; g < NOPS; g++) begin : g_opr
        always_ff @(posedge clk) begin
            if (!rst_n)
                opr_q[g] <= '0;
            else if (load_en)
                opr_q[g] <= {ser_in[g], opr_q[g][WIDTH-1:1]};
        end
    end

    // Multipliers: 0 = Wr*Br, 1 = Wi*Bi, 2 = Wr*Bi, 3 = Wi*Br.
    for (genvar m = 0; m < NMUL; m++) begin : g_mul
        localparam int QIDX = (m == 0 || m == 3) ? 2 : 3;
        logic mb;
        if (m % 2 == 0) begin : g_mr
            assign mb = mbit_r;
        end else begin : g_mi
            assign mb = mbit_i;
        end
        bsb_mult #(.WIDTH(WIDTH)) u_mul (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .acc_en   (acc_en),
            .shift_en (out_en),
            .last_row (last_row),
            .mbit     (mb),
            .row      (row),
            .col      (cnt),
            .q        (opr_q[QIDX]),
            .pbit     (pbit[m])
        );
    end

    // Sign-extended A bits for the current result position.
    always_comb begin
        if (int'(cnt) >= WIDTH - 1) begin
            a_bit_r = opr_q[0][WIDTH-1];
            a_bit_i = opr_q[1][WIDTH-1];
        end else begin
            a_bit_r = opr_q[0][cnt[RW-1:0]];
            a_bit_i = opr_q[1][cnt[RW-1:0]];
        end
    end

    // Real product: Wr*Br - Wi*Bi.
    bsb_cell u_tre (.clk(clk), .rst_n(rst_n), .en(out_en), .first(cnt == '0),
                    .sub(1'b1), .in_a(pbit[0]), .in_b(pbit[1]), .s(t_re));
    // Imaginary product: Wr*Bi + Wi*Br.
    bsb_cell u_tim (.clk(clk), .rst_n(rst_n), .en(out_en), .first(cnt == '0),
                    .sub(1'b0), .in_a(pbit[2]), .in_b(pbit[3]), .s(t_im));
    // Sum and difference with A.
    bsb_cell u_xre (.clk(clk), .rst_n(rst_n), .en(out_en), .first(cnt == '0),
                    .sub(1'b0), .in_a(a_bit_r), .in_b(t_re), .s(sx_re));
    bsb_cell u_xim (.clk(clk), .rst_n(rst_n), .en(out_en), .first(cnt == '0),
                    .sub(1'b0), .in_a(a_bit_i), .in_b(t_im), .s(sx_im));
    bsb_cell u_yre (.clk(clk), .rst_n(rst_n), .en(out_en), .first(cnt == '0),
                    .sub(1'b1), .in_a(a_bit_r), .in_b(t_re), .s(sy_re));
    bsb_cell u_yim (.clk(clk), .rst_n(rst_n), .en(out_en), .first(cnt == '0),
                    .sub(1'b1), .in_a(a_bit_i), .in_b(t_im), .s(sy_im));

    // Registered serial result lines, updated only while streaming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_re_q <= 1'b0;
            x_im_q <= 1'b0;
            y_re_q <= 1'b0;
            y_im_q <= 1'b0;
        end else if (out_en) begin
            x_re_q <= sx_re;
            x_im_q <= sx_im;
            y_re_q <= sy_re;
            y_im_q <= sy_im;
        end
    end

    assign x_re = x_re_q;
    assign x_im = x_im_q;
    assign y_re = y_re_q;
    assign y_im = y_im_q;

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) && !start) |=> (!finish && (st == ST_IDLE)));

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_OUT) |=> ($stable(x_re) && $stable(y_im)));
endmodule

// File: tb/tb_bsb_butterfly.sv
module tb_bsb_butterfly;
    localparam int W  = 8;
    localparam int OW = 2 * W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic a_re = 1'b0, a_im = 1'b0, b_re = 1'b0, b_im = 1'b0;
    logic w_re = 1'b0, w_im = 1'b0;
    logic x_re, x_im, y_re, y_im, finish;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    bsb_butterfly #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .w_re(w_re), .w_im(w_im),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
        .finish(finish)
    );

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL R4 watchdog: actual=%0d cycles expected<=100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Drive one butterfly and compare every cycle with a behavioural model.
    task automatic run(input int ar, input int ai, input int br, input int bi,
                       input int wr, input int wi, input bit poke,
                       input int idle, input string tag);
        longint xr, xi, yr, yi, pr, pi;
        int m, lat;
        m = 0;
        for (int j = 0; j < W; j++)
            m += (((wr >> j) & 1) | ((wi >> j) & 1)) ? 2 * W : 1;
        lat = W - 1 + m + OW;
        pr = longint'(wr) * br - longint'(wi) * bi;
        pi = longint'(wr) * bi + longint'(wi) * br;
        xr = ar + pr; xi = ai + pi; yr = ar - pr; yi = ai - pi;
        for (int e = 0; e <= lat; e++) begin
            @(negedge clk);
            if (e < W) begin
                start = (e == 0);
                a_re = ar[e]; a_im = ai[e]; b_re = br[e]; b_im = bi[e];
                w_re = wr[e]; w_im = wi[e];
            end else if (poke && (e == W + 2 || e == lat - 3)) begin
                start = 1'b1;
                a_re = 1'b1; a_im = 1'b0; b_re = 1'b1; b_im = 1'b1;
                w_re = 1'b1; w_im = 1'b1;
            end else begin
                start = 1'b0;
                a_re = 0; a_im = 0; b_re = 0; b_im = 0; w_re = 0; w_im = 0;
            end
            @(posedge clk);
            #1;
            // R3 R4: finish exactly on the predicted edge, nowhere else
            chk(finish == (e == lat), {tag, " R3 R4 finish"}, finish, (e == lat));
            if (e >= lat - OW + 1) begin
                int k;
                k = e - (lat - OW + 1);
                // R1 R2: result bit k of each output
                chk(x_re == xr[k], {tag, " R1 R2 x_re"}, x_re, xr[k]);
                chk(x_im == xi[k], {tag, " R2 x_im"}, x_im, xi[k]);
                chk(y_re == yr[k], {tag, " R2 y_re"}, y_re, yr[k]);
                chk(y_im == yi[k], {tag, " R2 y_im"}, y_im, yi[k]);
            end
        end
        @(negedge clk);
        start = 1'b0;
        a_re = 0; a_im = 0; b_re = 0; b_im = 0; w_re = 0; w_im = 0;
        for (int i = 0; i < idle; i++) begin
            @(posedge clk);
            #1;
            chk(finish == 1'b0, {tag, " R3 idle finish"}, finish, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R7: reset state
        chk({finish, x_re, x_im, y_re, y_im} == 5'b0, "R7 reset outputs",
            {finish, x_re, x_im, y_re, y_im}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(finish == 1'b0, "R7 idle after reset", finish, 0);

        // Sparse twiddle: low five rows skipped (R5 timing path)
        run(5, -3, 10, -7, 64, -32, 1'b0, 2, "R5 sparse");
        // Zero twiddle: all rows skipped, X = Y = A
        run(-77, 51, 99, -100, 0, 0, 1'b0, 1, "R5 zero-w");
        // Most negative operands everywhere, exercising the sign row
        run(-128, -128, -128, -128, -128, -128, 1'b0, 1, "R8 min");
        // Most positive operands
        run(127, 127, 127, 127, 127, 127, 1'b0, 1, "R8 max");
        // All-ones twiddle: no skipped rows
        run(1, -1, 3, -2, -1, -1, 1'b0, 1, "R4 dense");
        // Stray start pulses while busy
        run(40, -60, -33, 21, 90, -45, 1'b1, 1, "R6 busy-start");
        // Back-to-back: new start on the cycle after finish
        run(12, 34, -56, 78, -90, 11, 1'b0, 0, "R9 b2b-a");
        run(-1, 2, -3, 4, 5, -6, 1'b0, 1, "R9 b2b-b");
        // Mixed patterns
        for (int n = 0; n < 6; n++) begin
            int v [6];
            for (int i = 0; i < 6; i++) v[i] = int'($urandom_range(0, 255)) - 128;
            run(v[0], v[1], v[2], v[3], v[4], v[5], 1'b0, n % 2, "R2 mixed");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule